// File: doc/BRIEF.md
# Windowed Pulse Generator

This block runs a free binary counter from reset and derives two fixed pulse waveforms from it. Each waveform repeats once per counter period. The first output, `pulse_a`, is a short high window inside a long low period. The second output, `pulse_b`, is a long high level with one low gap. Both outputs come straight from flip-flops, so downstream logic sees clean registered levels with no decode glitches.

Each output flop is set or cleared only when the count reaches one of its programmed edge counts. At every other count it keeps its level. The compare uses the count one below the edge, so the registered output changes on exactly the count the waveform names.

The counter has two sections. The lower section increments on every clock. The upper section increments only when a registered carry from the lower section is present. That carry is formed one cycle early, which keeps the carry path short and still gives a plain binary sequence. The edge counts and the widths are elaboration parameters. The defaults are a 22-bit counter split into two 11-bit halves. With the defaults, `pulse_a` is high for counts 120 to 178 and `pulse_b` is low for counts 48000 to 48824.

Top module: `windowed_pulse_gen`

## Requirements
- R1: The count advances by one on each clock that does not assert reset. After the all-ones value (2^CNT_W − 1) it returns to 0, and both waveforms then repeat exactly.
- R2: `pulse_a` is 1 while the count is in [A_RISE, A_FALL − 1] and 0 at every other count (defaults 120 and 179).
- R3: `pulse_b` is 0 while the count is in [B_FALL, B_RISE − 1] and 1 at every other count (defaults 48000 and 48825).
- R4: Each output changes level only on the clock where the count becomes one of that output's two edge counts. At every other count it keeps its level.
- R5: On the clock where the lower LO_W bits of the count wrap from all ones to zero, the upper section increments in that same clock. No count value is repeated and no count value is skipped.
- R6: When `rst` is 1 on a rising clock edge, the count becomes 0, `pulse_a` becomes 0 and `pulse_b` becomes 1 after that edge. This holds whatever the outputs were before the edge.
- R7: An edge count that falls exactly on a lower-section wrap switches its output on that exact count. An edge count equal to the all-ones value also switches on that exact count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_a | output | 1 | Registered short high window |
| pulse_b | output | 1 | Registered high level with one low gap |

## Verification
Two events can land on the same clock: the lower section wrapping, which also increments the upper section, and an output edge. The second bench instance uses a 10-bit counter with a 4-bit lower section. Its `pulse_a` rises at 32 and falls at 48, and both counts are lower-section wraps. Its `pulse_b` rises at 1023, the last count of the period. These settings make an output edge land on a carry clock on purpose. A behavioural counter compares every output on every clock against range tests, so a carry that arrives late or early shows up as an edge one count away from the right one. A reset in the middle of the run checks that the outputs return to their reset levels and the count restarts from 0.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    // Returns the count that comes one step before an edge count, modulo the period.
    function automatic longint unsigned edge_pre(input longint unsigned edge_cnt,
                                                 input int unsigned    width);
        longint unsigned period;
        period = longint'(1) << width;
        return (edge_cnt + period - 1) % period;
    endfunction

endpackage

// File: rtl/wpg_split_counter.sv
module wpg_split_counter #(
    parameter int unsigned CNT_W = 22,
    parameter int unsigned LO_W  = 11
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count_o
);
    localparam int unsigned HI_W = CNT_W - LO_W;
    localparam logic [LO_W-1:0] LO_PRE = {{(LO_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
        logic            carry;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.lo    = st_q.lo + 1'b1;
        // carry is registered one cycle before the lower section is all ones
        st_d.carry = (st_q.lo == LO_PRE);
        if (st_q.carry) begin
            st_d.hi = st_q.hi + 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count_o = {st_q.hi, st_q.lo};

    logic seen_rst_q;
    always_ff @(posedge clk) begin
        if (rst) seen_rst_q <= 1'b1;
        else if (seen_rst_q !== 1'b1) seen_rst_q <= 1'b0;
    end

    // R1
    step_chk: assert property (@(posedge clk) disable iff (rst)
        seen_rst_q |=> count_o == CNT_W'($past(count_o) + 1'b1));

    // R5
    carry_align_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_rst_q && st_q.lo == {LO_W{1'b1}}) |-> st_q.carry);

    // R6
    cnt_reset_chk: assert property (@(posedge clk)
        rst |=> count_o == '0);

    initial begin
        assert (LO_W >= 2 && LO_W < CNT_W);
    end

endmodule

// File: rtl/wpg_level_track.sv
module wpg_level_track #(
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic level_o
);
    typedef struct packed {
        logic level;
    } lvl_st_t;

    lvl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.level = 1'b1;
        end else if (clr_i) begin
            st_d.level = 1'b0;
        end
        if (rst) begin
            st_d.level = RST_LEVEL;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign level_o = st_q.level;

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(level_o));

    // R4
    set_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> level_o);

    // R4
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !level_o);

    // R6
    lvl_reset_chk: assert property (@(posedge clk)
        rst |=> level_o == RST_LEVEL);

endmodule

// File: rtl/windowed_pulse_gen.sv
module windowed_pulse_gen #(
    parameter int unsigned CNT_W  = 22,
    parameter int unsigned LO_W   = 11,
    parameter int unsigned A_RISE = 120,
    parameter int unsigned A_FALL = 179,
    parameter int unsigned B_FALL = 48000,
    parameter int unsigned B_RISE = 48825
) (
    input  logic clk,
    input  logic rst,
    output logic pulse_a,
    output logic pulse_b
);
    import wpg_pkg::*;

    localparam logic [CNT_W-1:0] A_RISE_PRE = CNT_W'(edge_pre(A_RISE, CNT_W));
    localparam logic [CNT_W-1:0] A_FALL_PRE = CNT_W'(edge_pre(A_FALL, CNT_W));
    localparam logic [CNT_W-1:0] B_FALL_PRE = CNT_W'(edge_pre(B_FALL, CNT_W));
    localparam logic [CNT_W-1:0] B_RISE_PRE = CNT_W'(edge_pre(B_RISE, CNT_W));

    typedef struct packed {
        logic a_set;
        logic a_clr;
        logic b_set;
        logic b_clr;
    } hit_t;

    logic [CNT_W-1:0] count;
    hit_t             hit_d;

    wpg_split_counter #(
        .CNT_W (CNT_W),
        .LO_W  (LO_W)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .count_o (count)
    );

    // Equality against the count one step before each edge.
    always_comb begin
        hit_d       = '0;
        hit_d.a_set = (count == A_RISE_PRE);
        hit_d.a_clr = (count == A_FALL_PRE);
        hit_d.b_set = (count == B_RISE_PRE);
        hit_d.b_clr = (count == B_FALL_PRE);
    end

    wpg_level_track #(.RST_LEVEL(1'b0)) u_track_a (
        .clk     (clk),
        .rst     (rst),
        .set_i   (hit_d.a_set),
        .clr_i   (hit_d.a_clr),
        .level_o (pulse_a)
    );

    wpg_level_track #(.RST_LEVEL(1'b1)) u_track_b (
        .clk     (clk),
        .rst     (rst),
        .set_i   (hit_d.b_set),
        .clr_i   (hit_d.b_clr),
        .level_o (pulse_b)
    );

    // R2
    a_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (count == A_RISE_PRE) |=> pulse_a);

    // R3
    b_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (count == B_FALL_PRE) |=> !pulse_b);

    initial begin
        assert (A_RISE > 0 && A_RISE < A_FALL && A_FALL <= (1 << CNT_W));
        assert (B_FALL > 0 && B_FALL < B_RISE && B_RISE <= (1 << CNT_W));
    end

endmodule

// File: tb/windowed_pulse_gen_tb.sv
`timescale 1ns/1ps
module windowed_pulse_gen_tb;

    localparam int S_W = 10;
    localparam int S_LO = 4;
    localparam int S_AR = 32;
    localparam int S_AF = 48;
    localparam int S_BF = 400;
    localparam int S_BR = 1023;
    localparam int D_W = 22;
    localparam int D_LO = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pa_d, pb_d, pa_s, pb_s;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    windowed_pulse_gen u_dut (
        .clk(clk), .rst(rst), .pulse_a(pa_d), .pulse_b(pb_d)
    );

    windowed_pulse_gen #(
        .CNT_W(S_W), .LO_W(S_LO), .A_RISE(S_AR), .A_FALL(S_AF),
        .B_FALL(S_BF), .B_RISE(S_BR)
    ) u_dut_small (
        .clk(clk), .rst(rst), .pulse_a(pa_s), .pulse_b(pb_s)
    );

    // behavioural counters
    longint n_d = 0;
    longint n_s = 0;
    bit started = 1'b0;
    bit just_rst = 1'b0;
    bit wrapped_s = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            n_d <= 0; n_s <= 0; started <= 1'b1; just_rst <= 1'b1;
        end else begin
            n_d <= (n_d + 1) % (longint'(1) << D_W);
            n_s <= (n_s + 1) % (longint'(1) << S_W);
            if (n_s == (longint'(1) << S_W) - 1) wrapped_s <= 1'b1;
            just_rst <= 1'b0;
        end
    end

    function automatic string tag_of(longint n, int lo, longint e1, longint e2,
                                     bit jr, string base);
        if (jr) return "R6";
        if (n == 0) return "R1";
        if ((n == e1 || n == e2) && (n % (longint'(1) << lo)) == 0) return "R7";
        if (n == e1 || n == e2) return "R4";
        if ((n % (longint'(1) << lo)) == 0) return "R5";
        return base;
    endfunction

    task automatic cmp(string tag, string what, logic act, logic exp, longint n);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at count %0d: actual %b expected %b", tag, what, n, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            logic ea, eb;
            ea = (n_d >= 120 && n_d < 179);
            eb = !(n_d >= 48000 && n_d < 48825);
            cmp(tag_of(n_d, D_LO, 120, 179, just_rst, "R2"), "dflt pulse_a", pa_d, ea, n_d);
            cmp(tag_of(n_d, D_LO, 48000, 48825, just_rst, "R3"), "dflt pulse_b", pb_d, eb, n_d);
            ea = (n_s >= S_AR && n_s < S_AF);
            eb = !(n_s >= S_BF && n_s < S_BR);
            cmp(tag_of(n_s, S_LO, S_AR, S_AF, just_rst, "R2"), "small pulse_a", pa_s, ea, n_s);
            cmp(tag_of(n_s, S_LO, S_BF, S_BR, just_rst, "R3"), "small pulse_b", pb_s, eb, n_s);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // run until the small instance sits inside its pulse_a window
        repeat (20000) @(negedge clk);
        while (!pa_s) @(negedge clk);
        // R6: reset while pulse_a of the small instance is high
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (52000) @(negedge clk);
        // R1: the small instance has passed its wrap at least once
        checks++;
        if (!wrapped_s) begin
            errors++;
            $display("FAIL R1 wrap not reached: actual 0 expected 1");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule